// File: doc/BRIEF.md
# Eight-Output Addressable Latch

This block keeps eight independent single-bit storage cells and shows all of them in parallel on one output bus. A 3-bit binary address picks one cell and a single data line supplies the value for it. Two active-low controls, `wr_en_n` (latch enable) and `clr_n` (master reset), are sampled together on every clock edge. Their combination selects one of four operating modes for that cycle. The block is a clocked equivalent of a transparent latch bank: the value that a latch would show while transparent appears on `q` one edge after the inputs are presented.

The four modes are the states of a small controller. The controller moves from any mode to any other on each edge, as the sampled pair of controls dictates:
- STEER (`wr_en_n`=0, `clr_n`=0): the addressed cell takes the data bit and every other cell is cleared.
- WRITE (`wr_en_n`=0, `clr_n`=1): the addressed cell takes the data bit and the other cells keep their contents.
- HOLD (`wr_en_n`=1, `clr_n`=1): every cell keeps its contents and ignores the data and address inputs.
- CLEAR (`wr_en_n`=1, `clr_n`=0): all cells are zeroed.

An asynchronous active-low `rst_n` forces the CLEAR state and zeroes all cells. Without it the contents would be undefined until the first CLEAR or write.

Top module: `addr_latch8`

## Requirements
- R1: While `rst_n` is low, and after it is released, `q` reads all zero.
- R2: With `wr_en_n`=0 and `clr_n`=0 at an edge, `q` after that edge has bit `sel` equal to `din` and all other bits 0.
- R3: With `wr_en_n`=1 and `clr_n`=1 at an edge, `q` is unchanged after that edge, whatever `din` and `sel` are.
- R4: With `wr_en_n`=0 and `clr_n`=1 at an edge, bit `sel` of `q` equals `din` after that edge.
- R5: In the mode of R4, the seven bits not addressed keep their values.
- R6: With `wr_en_n`=1 and `clr_n`=0 at an edge, `q` is all zero after that edge.
- R7: Address value n (0 to 7) selects bit n of `q`, where bit 0 is the least significant bit.
- R8: When the address changes between edges in the mode of R4, the bit addressed before keeps the last value it took, and the newly addressed bit takes `din`.
- R9: Zeros written by the modes of R2 and R6 remain in `q` after the controls switch to the mode of R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset; zeroes all cells |
| wr_en_n | input | 1 | Active-low latch enable |
| clr_n | input | 1 | Active-low master reset control |
| sel | input | 3 | Binary address of the target cell |
| din | input | 1 | Data bit for the addressed cell |
| q | output | 8 | Parallel contents of the eight cells |

## Verification
Every mode produces its result exactly one clock edge after the controls, address and data are presented, because each cell is a single register and there is no other stage on the path. The driver changes inputs on the falling edge and queues the expected word for the next rising edge. The monitor compares one nanosecond after that rising edge, so each comparison falls one cycle after its stimulus and away from any edge. The reset value is compared directly once `rst_n` has been released, before any stimulus is queued.

// File: rtl/addr_latch8_pkg.sv
package addr_latch8_pkg;

    typedef enum logic [1:0] {
        MODE_STEER = 2'b00,
        MODE_WRITE = 2'b01,
        MODE_CLEAR = 2'b10,
        MODE_HOLD  = 2'b11
    } lat_mode_e;

endpackage

// File: rtl/addr_latch8_ctrl.sv
module addr_latch8_ctrl
    import addr_latch8_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_en_n,
    input  logic      clr_n,
    output lat_mode_e mode_next,
    output lat_mode_e mode_q
);

    // Next-mode decode from the sampled control pair.
    always_comb begin
        unique case ({wr_en_n, clr_n})
            2'b00:   mode_next = MODE_STEER;
            2'b01:   mode_next = MODE_WRITE;
            2'b10:   mode_next = MODE_CLEAR;
            default: mode_next = MODE_HOLD;
        endcase
    end

    // State register: remembers the mode applied at the last edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_CLEAR;
        end else begin
            mode_q <= mode_next;
        end
    end

endmodule

// File: rtl/addr_latch8_dec.sv
module addr_latch8_dec #(
    parameter int NUM_CELLS = 8,
    localparam int ADDR_W   = $clog2(NUM_CELLS)
) (
    input  logic [ADDR_W-1:0]    sel,
    output logic [NUM_CELLS-1:0] hit
);

    for (genvar i = 0; i < NUM_CELLS; i++) begin : g_hit
        assign hit[i] = (sel == ADDR_W'(i));
    end

    always_comb begin
        a_hit_onehot_r7: assert ($isunknown(sel) || $onehot0(hit));
    end

endmodule

// File: rtl/addr_latch8_cells.sv
module addr_latch8_cells
    import addr_latch8_pkg::*;
#(
    parameter int NUM_CELLS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  lat_mode_e            mode,
    input  logic [NUM_CELLS-1:0] hit,
    input  logic                 din,
    output logic [NUM_CELLS-1:0] q
);

    for (genvar i = 0; i < NUM_CELLS; i++) begin : g_cell
        logic cell_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cell_q <= 1'b0;
            end else begin
                unique case (mode)
                    MODE_STEER: cell_q <= hit[i] & din;
                    MODE_WRITE: cell_q <= hit[i] ? din : cell_q;
                    MODE_CLEAR: cell_q <= 1'b0;
                    MODE_HOLD:  cell_q <= cell_q;
                endcase
            end
        end

        assign q[i] = cell_q;
    end

endmodule

// File: rtl/addr_latch8.sv
module addr_latch8
    import addr_latch8_pkg::*;
#(
    parameter int NUM_CELLS = 8,
    localparam int ADDR_W   = $clog2(NUM_CELLS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en_n,
    input  logic                 clr_n,
    input  logic [ADDR_W-1:0]    sel,
    input  logic                 din,
    output logic [NUM_CELLS-1:0] q
);

    lat_mode_e            mode_next;
    lat_mode_e            mode_q;
    logic [NUM_CELLS-1:0] hit;

    addr_latch8_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_n   (wr_en_n),
        .clr_n     (clr_n),
        .mode_next (mode_next),
        .mode_q    (mode_q)
    );

    addr_latch8_dec #(.NUM_CELLS(NUM_CELLS)) u_dec (
        .sel (sel),
        .hit (hit)
    );

    addr_latch8_cells #(.NUM_CELLS(NUM_CELLS)) u_cells (
        .clk   (clk),
        .rst_n (rst_n),
        .mode  (mode_next),
        .hit   (hit),
        .din   (din),
        .q     (q)
    );

    // R2: steer leaves only the addressed bit, carrying the data.
    p_steer_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_n && !clr_n) |=>
        (q == (NUM_CELLS'($past(din)) << $past(sel))));

    // R3: hold mode keeps every bit.
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_HOLD) |-> $stable(q));

    // R4: write mode loads the addressed bit.
    p_write_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_n && clr_n) |=> (q[$past(sel)] == $past(din)));

    // R5: write mode changes at most one bit.
    p_write_others_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_n && clr_n) |=> ($countones(q ^ $past(q)) <= 1));

    // R6: the controller's clear state goes with an empty word.
    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_CLEAR) |-> (q == '0));

endmodule

// File: tb/addr_latch8_test.sv
`timescale 1ns/100ps
module addr_latch8_test;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } sb_item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en_n = 1'b1;
    logic       clr_n = 1'b1;
    logic [2:0] sel = 3'd0;
    logic       din = 1'b0;
    logic [7:0] q;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    sb_item_t   sb_q[$];
    logic [7:0] model = 8'h00;

    addr_latch8 uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en_n (wr_en_n),
        .clr_n   (clr_n),
        .sel     (sel),
        .din     (din),
        .q       (q)
    );

    always #2.5 clk = ~clk;

    // Driver: apply at the falling edge, queue the word due after the next rising edge.
    task automatic apply(input logic le, input logic mr, input logic [2:0] a,
                         input logic d, input string tag);
        sb_item_t it;
        @(negedge clk);
        wr_en_n = le;
        clr_n   = mr;
        sel     = a;
        din     = d;
        case ({le, mr})
            2'b00: begin model = 8'h00; model[a] = d; end
            2'b01: model[a] = d;
            2'b10: model = 8'h00;
            default: model = model;
        endcase
        it.exp = model;
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    // Monitor: one result per rising edge, compared 1 ns after it.
    initial begin
        sb_item_t it;
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                it = sb_q.pop_front();
                tests++;
                if (q !== it.exp) begin
                    fails++;
                    $display("FAIL %s: q=%b expected=%b", it.tag, q, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        tests++;
        if (q !== 8'h00) begin
            fails++;
            $display("FAIL R1: q=%b expected=%b during reset", q, 8'h00);
        end
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        tests++;
        if (q !== 8'h00) begin
            fails++;
            $display("FAIL R1: q=%b expected=%b after release", q, 8'h00);
        end

        apply(1'b1, 1'b0, 3'd0, 1'b1, "R6 clear from reset");

        // R4 R7: write each address with pattern 10100101.
        for (int i = 0; i < 8; i++)
            apply(1'b0, 1'b1, 3'(i), ((8'hA5 >> i) & 8'h01) != 0, "R4 R7 write per address");

        // R3: hold while data and address wander.
        for (int i = 0; i < 8; i++)
            apply(1'b1, 1'b1, 3'(7 - i), i[0], "R3 hold ignores inputs");

        // R5: rewrite one bit, the other seven keep their values.
        apply(1'b0, 1'b1, 3'd1, 1'b1, "R5 write bit1 others keep");
        apply(1'b0, 1'b1, 3'd7, 1'b0, "R5 write bit7 others keep");

        // R8: address moves during write mode.
        apply(1'b0, 1'b1, 3'd3, 1'b1, "R8 write bit3");
        apply(1'b0, 1'b1, 3'd4, 1'b1, "R8 bit3 kept, bit4 follows");
        apply(1'b0, 1'b1, 3'd4, 1'b0, "R8 bit4 follows 0");
        apply(1'b0, 1'b1, 3'd6, 1'b0, "R8 bit4 kept at 0");

        // R2: steer at each address with data 1, then with data 0.
        for (int i = 0; i < 8; i++)
            apply(1'b0, 1'b0, 3'(i), 1'b1, "R2 R7 steer data 1");
        apply(1'b0, 1'b0, 3'd5, 1'b0, "R2 steer data 0");

        // R9: steer then hold keeps zeros elsewhere.
        apply(1'b0, 1'b0, 3'd2, 1'b1, "R2 steer bit2");
        apply(1'b1, 1'b1, 3'd6, 1'b1, "R9 hold after steer");
        apply(1'b1, 1'b1, 3'd0, 1'b0, "R9 hold after steer again");

        // R6 R9: fill, clear, hold.
        for (int i = 0; i < 8; i++)
            apply(1'b0, 1'b1, 3'(i), 1'b1, "R4 fill all ones");
        apply(1'b1, 1'b0, 3'd3, 1'b1, "R6 clear all");
        apply(1'b1, 1'b1, 3'd3, 1'b1, "R9 hold after clear");
        apply(1'b0, 1'b1, 3'd0, 1'b1, "R4 write after clear");

        @(negedge clk);
        wr_en_n = 1'b1;
        clr_n   = 1'b1;
        repeat (3) @(posedge clk);
        #2;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule